// File: doc/BRIEF.md
# Password-Gated Pin Write Lock

This block guards the configuration of a bank-organised GPIO controller against stray writes. It holds one lock word per bank, one bit per pin. A bit at 1 freezes that pin, and a bit at 0 leaves it free. The controller next to this block reads the flattened `lock_vec` output. It uses the output to discard writes to a locked pin's control word and to that pin's bits in the output set and output clear registers.

The lock words sit on the same simple register bus as the rest of the controller. A lock word can only be replaced by a write that follows a key write carrying the correct password. Each correct key write arms exactly one lock write, and that write may go to any bank. Any other bus write disarms the block. A lock write made while disarmed is dropped. Both the lock words and the key register can be read back, and the key always reads as zero.

Top module: `pinlock_gate`

## Requirements
- R1: After synchronous reset, every bit of `lock_vec` is 1 (all pins locked) and `bus_rvalid` is 0.
- R2: A write of 0x00A5A501 to the key address 0x520 arms the block. A following write to lock address 0x500 + 4*b replaces bank b's lock word, and the new value appears on `lock_vec` one clock after that write.
- R3: A write to a lock address while the block is not armed leaves every lock word unchanged.
- R4: The arm is one-shot. After an armed lock write, a second lock write without a new key write is ignored.
- R5: A key write with any value other than the password disarms the block, so the next lock write is ignored.
- R6: A write to any address that is neither the key address nor a lock address disarms the block. This includes the word just past the last bank and misaligned addresses.
- R7: An armed lock write changes only the addressed bank. The other banks keep their lock words.
- R8: Bit i of bank b's lock word drives `lock_vec[b*32+i]`. Writing all ones locks every pin of the bank, and writing all zeros unlocks every pin.
- R9: One clock after `bus_rd` is sampled high, `bus_rvalid` is 1. At that point `bus_rdata` holds the addressed lock word, or 0 for the key address or any other address. `bus_rvalid` is 0 one clock after a cycle without a read.
- R10: The arm persists through cycles without a bus write, so a lock write that comes several idle cycles after the key write is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one clock after `bus_rd` |
| lock_vec | output | NUM_BANKS*DATA_W (128) | Per-pin lock flags, bank-major |

## Verification
The lock path is tried with five write sequences:
- a lock write with no key before it;
- key then lock;
- key then two lock writes;
- key, wrong key, then lock;
- key, an unrelated write, then lock.

Only the key-then-lock sequence may change state, so these runs separate a design that arms on any key write, one that never disarms, and one that disarms only on lock writes. An unrelated write to the address just past the last bank probes the edge of the lock decode. A lock write after idle cycles shows that the arm is not a timer.

Lock values of all ones, all zeros and a mixed pattern are written to different banks and then read back. This shows that bits are not swapped between banks and that the untouched banks hold their values.

// File: rtl/pinlock_pkg.sv
// Shared definitions for the pin write-lock block.
// Assumes a byte-addressed register bus with 32-bit words.
package pinlock_pkg;

    // Password that arms a single lock word update
    localparam logic [31:0] PL_DEFAULT_KEY = 32'h00A5A501;

    // Kind of register an address selects
    typedef enum logic [1:0] {
        ACC_OTHER = 2'd0,
        ACC_KEY   = 2'd1,
        ACC_LOCK  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/pinlock_decode.sv
// Address decoder: classifies a bus address as key, lock word or other,
// and yields the bank index for lock words.
// Assumes lock words are word aligned at LOCK_BASE + 4*bank and that the
// key address lies outside the lock window.
module pinlock_decode #(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_BANKS = 4,
    parameter int          BANK_W    = 2,
    parameter logic [11:0] KEY_ADDR  = 12'h520,
    parameter logic [11:0] LOCK_BASE = 12'h500
) (
    input  logic [ADDR_W-1:0]      addr,
    output pinlock_pkg::acc_kind_e kind,
    output logic [BANK_W-1:0]      bank
);
    import pinlock_pkg::*;

    // Compare against every lock word address and the key address
    always_comb begin
        kind = ACC_OTHER;
        bank = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(LOCK_BASE + 4 * b)) begin
                kind = ACC_LOCK;
                bank = BANK_W'(b);
            end
        end
        if (addr == ADDR_W'(KEY_ADDR)) begin
            kind = ACC_KEY;
        end
    end

endmodule

// File: rtl/pinlock_arm.sv
// One-shot arming logic. A correct key write sets the arm. Every other write
// clears it, including a lock write, which it allows to commit if armed.
// Assumes at most one write per clock.
module pinlock_arm #(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] PASSWORD = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  pinlock_pkg::acc_kind_e kind,
    input  logic [DATA_W-1:0]      wdata,
    output logic                   armed,
    output logic                   commit
);
    import pinlock_pkg::*;

    logic key_ok;

    // Password match on a key write
    always_comb key_ok = (kind == ACC_KEY) && (wdata == PASSWORD);

    // Lock write allowed only while armed
    always_comb commit = wr && (kind == ACC_LOCK) && armed;

    // Arm state: any write reloads it, idle cycles hold it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (wr) begin
            armed <= key_ok;
        end
    end

endmodule

// File: rtl/pinlock_store.sv
// Lock word storage, one register per bank, flattened bank-major onto lock_vec.
// Assumes commit is asserted only for an armed lock write.
module pinlock_store #(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 32,
    parameter int BANK_W    = 2,
    localparam int LOCK_W   = NUM_BANKS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [BANK_W-1:0] sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [LOCK_W-1:0] lock_vec
);
    logic [DATA_W-1:0] word_q [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        // Bank word: locked out of reset, replaced on a committed write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '1;
            end else if (commit && (sel == BANK_W'(g))) begin
                word_q[g] <= wdata;
            end
        end

        // Expose the word on its slice of the lock vector
        assign lock_vec[g*DATA_W +: DATA_W] = word_q[g];
    end

endmodule

// File: rtl/pinlock_readback.sv
// Registered read port: returns the addressed lock word, or zero for the
// key register and unmapped addresses.
// Assumes lock_vec is bank-major with DATA_W bits per bank.
module pinlock_readback #(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 32,
    parameter int BANK_W    = 2,
    localparam int LOCK_W   = NUM_BANKS * DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd,
    input  pinlock_pkg::acc_kind_e kind,
    input  logic [BANK_W-1:0]      sel,
    input  logic [LOCK_W-1:0]      lock_vec,
    output logic [DATA_W-1:0]      rdata,
    output logic                   rvalid
);
    import pinlock_pkg::*;

    logic [DATA_W-1:0] word_sel;

    // Pick the addressed bank word
    always_comb word_sel = lock_vec[sel*DATA_W +: DATA_W];

    // Register the response one clock after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd;
            rdata  <= (rd && kind == ACC_LOCK) ? word_sel : '0;
        end
    end

endmodule

// File: rtl/pinlock_gate.sv
// Top of the password-gated per-pin write lock.
// The neighbouring GPIO controller consumes lock_vec to drop writes to locked
// pins. Assumes one bus access per clock and that bus_wr and bus_rd share bus_addr.
module pinlock_gate #(
    parameter int                NUM_BANKS = 4,
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 12,
    parameter logic [11:0]       KEY_ADDR  = 12'h520,
    parameter logic [11:0]       LOCK_BASE = 12'h500,
    parameter logic [DATA_W-1:0] PASSWORD  = DATA_W'(pinlock_pkg::PL_DEFAULT_KEY),
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int LOCK_W = NUM_BANKS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [LOCK_W-1:0] lock_vec
);
    import pinlock_pkg::*;

    acc_kind_e         kind;
    logic [BANK_W-1:0] bank;
    logic              arm_q;
    logic              commit;

    pinlock_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BANKS(NUM_BANKS),
        .BANK_W   (BANK_W),
        .KEY_ADDR (KEY_ADDR),
        .LOCK_BASE(LOCK_BASE)
    ) u_decode (
        .addr(bus_addr),
        .kind(kind),
        .bank(bank)
    );

    pinlock_arm #(
        .DATA_W  (DATA_W),
        .PASSWORD(PASSWORD)
    ) u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .kind  (kind),
        .wdata (bus_wdata),
        .armed (arm_q),
        .commit(commit)
    );

    pinlock_store #(
        .NUM_BANKS(NUM_BANKS),
        .DATA_W   (DATA_W),
        .BANK_W   (BANK_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .sel     (bank),
        .wdata   (bus_wdata),
        .lock_vec(lock_vec)
    );

    pinlock_readback #(
        .NUM_BANKS(NUM_BANKS),
        .DATA_W   (DATA_W),
        .BANK_W   (BANK_W)
    ) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .kind    (kind),
        .sel     (bank),
        .lock_vec(lock_vec),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );

endmodule

// File: rtl/pinlock_gate_chk.sv
// Property checker for pinlock_gate, bound to every instance of the top.
// Decodes the bus address independently and watches the arm state.
module pinlock_gate_chk #(
    parameter int                NUM_BANKS = 4,
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 12,
    parameter logic [11:0]       KEY_ADDR  = 12'h520,
    parameter logic [11:0]       LOCK_BASE = 12'h500,
    parameter logic [DATA_W-1:0] PASSWORD  = '0,
    localparam int LOCK_W = NUM_BANKS * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic [LOCK_W-1:0] lock_vec,
    input logic              armed
);
    logic key_hit;
    logic lock_hit;
    int   hit_bank;

    // Independent address classification
    always_comb begin
        key_hit  = (bus_addr == ADDR_W'(KEY_ADDR));
        lock_hit = 1'b0;
        hit_bank = 0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(LOCK_BASE + 4 * b)) begin
                lock_hit = 1'b1;
                hit_bank = b;
            end
        end
    end

    AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&lock_vec && !bus_rvalid)); // R1

    AST_GOOD_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && key_hit && bus_wdata == PASSWORD) |=> armed); // R2

    AST_ARMED_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && lock_hit && armed)
            |=> lock_vec[$past(hit_bank)*DATA_W +: DATA_W] == $past(bus_wdata)); // R2

    AST_UNARMED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && lock_hit && !armed) |=> $stable(lock_vec)); // R3

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && lock_hit) |=> !armed); // R4

    AST_BAD_KEY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && key_hit && bus_wdata != PASSWORD) |=> !armed); // R5

    AST_OTHER_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !key_hit && !lock_hit) |=> (!armed && $stable(lock_vec))); // R6

    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R9

    AST_NO_RD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid); // R9

    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !lock_hit) |=> (bus_rdata == '0)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(armed) && $stable(lock_vec))); // R10

endmodule

bind pinlock_gate pinlock_gate_chk #(
    .NUM_BANKS(NUM_BANKS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .KEY_ADDR (KEY_ADDR),
    .LOCK_BASE(LOCK_BASE),
    .PASSWORD (PASSWORD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .lock_vec  (lock_vec),
    .armed     (arm_q)
);

// File: tb/test_pinlock_gate.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected read data and the monitor
// compares it against bus_rdata; lock_vec is checked after each write.
module test_pinlock_gate;
    localparam int NB  = 4;
    localparam int DW  = 32;
    localparam int AW  = 12;
    localparam logic [11:0] KEY   = 12'h520;
    localparam logic [11:0] LBASE = 12'h500;
    localparam logic [31:0] PW    = 32'h00A5A501;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic            bus_rvalid;
    logic [NB*DW-1:0] lock_vec;

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    logic [31:0] model [NB];
    bit model_arm = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    pinlock_gate i_pinlock_gate (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .lock_vec(lock_vec)
    );

    // Generic compare with counters
    task automatic check(input string tag, input logic [NB*DW-1:0] act, input logic [NB*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_locks(input string tag);
        logic [NB*DW-1:0] e;
        for (int b = 0; b < NB; b++) e[b*DW +: DW] = model[b];
        check(tag, lock_vec, e);
    endtask

    // Driver: one write, model updated from the requirements
    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        int hit;
        hit = -1;
        for (int b = 0; b < NB; b++) if (a == AW'(LBASE + 4 * b)) hit = b;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == KEY) model_arm = (d == PW);
        else begin
            if (hit >= 0 && model_arm) model[hit] = d;
            model_arm = 0;
        end
    endtask

    // Driver: one read, expected value pushed to the scoreboard
    task automatic do_read(input logic [AW-1:0] a, input string tag);
        logic [31:0] e;
        e = '0;
        for (int b = 0; b < NB; b++) if (a == AW'(LBASE + 4 * b)) e = model[b];
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: pop and compare each read response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_errors++;
                $display("FAIL R9 unexpected rvalid actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    mon_errors++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic finish_run;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 missing reads actual=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) model[b] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_locks("R1 reset locks");
        check("R1 rvalid idle", {{(NB*DW-1){1'b0}}, bus_rvalid}, '0);

        do_read(LBASE, "R9 bank0 after reset");
        do_read(KEY, "R9 key reads zero");
        do_read(12'h040, "R9 unmapped reads zero");

        do_write(LBASE, 32'h0);
        check_locks("R3 unarmed write ignored");

        do_write(KEY, PW);
        do_write(LBASE + 4, 32'h1234_5678);
        check_locks("R2 R7 armed write bank1 only");

        do_write(LBASE + 4, 32'h0);
        check_locks("R4 second write ignored");

        do_write(KEY, PW);
        do_write(KEY, 32'h00A5A500);
        do_write(LBASE + 8, 32'h0);
        check_locks("R5 wrong key disarms");

        do_write(KEY, PW);
        do_write(12'h040, 32'hFFFF_0000);
        do_write(LBASE + 8, 32'h0);
        check_locks("R6 other write disarms");

        do_write(KEY, PW);
        do_write(LBASE + 4 * NB, 32'h0);
        do_write(LBASE, 32'h0);
        check_locks("R6 past-last-bank write disarms");

        do_write(KEY, PW);
        do_write(KEY + 1, PW);
        do_write(LBASE, 32'h0);
        check_locks("R6 misaligned write disarms");

        do_write(KEY, PW);
        repeat (6) @(negedge clk);
        do_write(LBASE + 12, 32'h0);
        check_locks("R10 R8 arm survives idle, bank3 unlocked");

        do_write(KEY, PW);
        do_write(LBASE + 12, 32'hFFFF_FFFF);
        check_locks("R8 bank3 relocked");

        do_write(KEY, PW);
        do_write(LBASE, 32'h0);
        check_locks("R8 bank0 all zeros");
        check("R8 bit map bank0 bit0", {{(NB*DW-1){1'b0}}, lock_vec[0]}, '0);
        check("R8 bit map bank1 bit3", {{(NB*DW-1){1'b0}}, lock_vec[DW + 3]}, {{(NB*DW-1){1'b0}}, 1'b1});

        for (int b = 0; b < NB; b++) do_read(AW'(LBASE + 4 * b), "R9 R7 bank readback");
        do_read(KEY, "R9 key still zero");

        repeat (3) @(negedge clk);
        check("R9 rvalid low after reads", {{(NB*DW-1){1'b0}}, bus_rvalid}, '0);
        finish_run();
    end

endmodule